// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters from a single data line. A clock enable pulses at sixteen times the bit rate, and the block samples the line on each pulse. A falling edge starts a frame only if the start bit still reads low at mid-bit. Each bit is resolved by a majority vote of three mid-bit samples. Characters carry eight or nine data bits and are sent least significant bit first. When parity is enabled, the top bit of the character is taken as the parity bit. The block checks it against the selected sense and clears it from the delivered data. A stop bit that reads low is reported as a framing error.

The block also measures how long the line has stayed high. It raises an idle pulse once the line has been high for one full frame time. The count can begin after the start bit or only after the stop bit. The first choice can falsely report idle after a character made of all ones, and the second does not.

A sleep request puts the receiver to sleep. While asleep, the block reports no data and no error flags. It wakes by itself on one of two selectable conditions. The first is a character whose most significant bit is 1, and that character is delivered normally. The second is an idle pulse. The data line is expected to be already synchronised to the clock.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, rx_valid, rx_par_err, rx_frm_err, rx_idle and asleep are all 0. With every cfg input at 0, the block uses 8-bit characters, no parity, idle-line wakeup and idle counting from the end of the start bit.
- R2: A high-to-low transition of rxd on an os_tick begins a start bit, and that tick counts as sample 1. Each bit takes the majority of its samples 7, 8 and 9. If the start bit votes 1, the block goes back to hunting and delivers nothing. A single high sample among the three still gives a valid start.
- R3: With cfg_nine=0, the 8 data bits are taken LSB first, and rx_data holds them zero-extended to 9 bits. rx_valid is high for exactly one clock, one clock after the os_tick edge that takes sample 9 of the stop bit. rx_data holds its value until the next delivery.
- R4: With cfg_nine=1, 9 data bits are received LSB first and delivered on rx_data[8:0].
- R5: With cfg_par_en=1, the parity bit is the top character bit: bit 7 in 8-bit mode, bit 8 in 9-bit mode. cfg_par_odd=0 selects even parity and cfg_par_odd=1 selects odd parity. The parity bit is cleared in rx_data. rx_par_err is high alongside rx_valid when the count of ones across the whole character, parity bit included, does not match the selected sense.
- R6: When the stop bit votes 0, rx_frm_err is high alongside rx_valid.
- R7: rx_idle pulses for one clock when the line has been high for 16*(N+2) consecutive counted os_ticks, where N is 8 or 9. It pulses only once per high run and re-arms after any low sample.
- R8: With cfg_idle_after_stop=0, counting runs from the end of the start bit. A 0xFF character followed by two high bit times is therefore reported as idle.
- R9: With cfg_idle_after_stop=1, counting starts only after the stop bit has been sampled. The same 0xFF sequence gives no idle pulse, but a full high frame time afterwards still does.
- R10: sleep_req sets asleep one clock later. While asleep, characters give no rx_valid, rx_par_err or rx_frm_err.
- R11: With cfg_wake_addr=1, an asleep receiver wakes on a character whose top bit is 1. That character is delivered in the same clock that asleep falls. A character whose top bit is 0 leaves it asleep.
- R12: With cfg_wake_addr=0, an asleep receiver wakes on an idle pulse, and asleep falls in the clock in which rx_idle is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Clock enable at 16x bit rate |
| rxd | input | 1 | Serial data line, idle high |
| cfg_nine | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| cfg_wake_addr | input | 1 | 1 selects wake on top-bit-set character, 0 selects wake on idle |
| cfg_idle_after_stop | input | 1 | 1 starts idle counting after the stop bit, 0 after the start bit |
| cfg_par_en | input | 1 | Treat the top character bit as parity |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| sleep_req | input | 1 | One-clock request to enter sleep |
| rx_data | output | 9 | Last delivered character, parity bit cleared |
| rx_valid | output | 1 | One-clock delivery strobe |
| rx_par_err | output | 1 | Parity mismatch, valid with rx_valid |
| rx_frm_err | output | 1 | Stop bit read low, valid with rx_valid |
| rx_idle | output | 1 | One-clock idle-line pulse |
| asleep | output | 1 | Receiver is asleep |

## Verification
Every output is registered. rx_valid, rx_data and both error flags therefore appear exactly one clock after the os_tick edge that takes sample 9 of the stop bit. rx_idle appears one clock after the tick that completes the high run. asleep changes one clock after sleep_req or after the waking tick. The bench drives each tick as one clock with os_tick high followed by one clock with it low. It steps a behavioural reference model on every driven clock and compares all six outputs at the next falling edge. On clocks without a tick, it therefore also confirms that the strobes stay low and that the data holds. Scenario checks then count the delivered characters and idle pulses over whole sequences. These cover false starts, the false idle after start bit, and the two wake paths.

// File: rtl/uart_rx_wake_pkg.sv
package uart_rx_wake_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RX   = 1'b1
    } rx_st_e;

endpackage

// File: rtl/urw_frame_rx.sv
module urw_frame_rx
    import uart_rx_wake_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rxd,
    input  logic            nine,
    output logic            done,
    output logic            stop_ok,
    output logic            hunting,
    output logic            in_start,
    output logic [DMAX-1:0] shreg
);
    localparam int CW = $clog2(OSR) + 1;
    localparam int IW = $clog2(DMAX + 2);
    localparam logic [CW-1:0] S_A   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] S_B   = CW'(OSR / 2);
    localparam logic [CW-1:0] S_C   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] S_END = CW'(OSR);

    typedef struct packed {
        rx_st_e          st;
        logic            prev;
        logic [CW-1:0]   sub;
        logic [IW-1:0]   idx;
        logic [1:0]      smp;
        logic [DMAX-1:0] sh;
    } frx_t;

    frx_t q, d;
    logic [CW-1:0] s;
    logic [IW-1:0] last_idx;
    logic          vote;

    always_comb begin
        d        = q;
        done     = 1'b0;
        stop_ok  = 1'b0;
        s        = q.sub + CW'(1);
        last_idx = nine ? IW'(DMAX + 1) : IW'(DMAX);
        vote     = (q.smp[0] & q.smp[1]) | (q.smp[0] & rxd) | (q.smp[1] & rxd);
        if (tick) begin
            d.prev = rxd;
            if (q.st == ST_HUNT) begin
                if (q.prev && !rxd) begin
                    d.st  = ST_RX;
                    d.sub = CW'(1);
                    d.idx = '0;
                end
            end else begin
                d.sub = s;
                if (s == S_A) d.smp[0] = rxd;
                if (s == S_B) d.smp[1] = rxd;
                if (s == S_C) begin
                    if (q.idx == '0) begin
                        if (vote) begin
                            d.st  = ST_HUNT;
                            d.sub = '0;
                        end
                    end else if (q.idx == last_idx) begin
                        done    = 1'b1;
                        stop_ok = vote;
                        d.st    = ST_HUNT;
                        d.sub   = '0;
                    end else begin
                        d.sh = {vote, q.sh[DMAX-1:1]};
                    end
                end
                if (s == S_END) begin
                    d.sub = '0;
                    d.idx = q.idx + IW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hunting  = (q.st == ST_HUNT);
    assign in_start = (q.st == ST_RX) && (q.idx == '0);
    assign shreg    = q.sh;

    AST_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_start && $past(hunting)) |-> $past(tick && !rxd)); // R2

endmodule

// File: rtl/urw_idle_det.sv
module urw_idle_det #(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic en,
    input  logic nine,
    output logic idle_pulse
);
    localparam int TMAX = OSR * (DMAX + 2);
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } idl_t;

    idl_t q, d;
    logic [CW-1:0] thr;

    always_comb begin
        d          = q;
        idle_pulse = 1'b0;
        thr        = nine ? CW'(TMAX) : CW'(OSR * (DMAX + 1));
        if (tick) begin
            if (rxd && en) begin
                if (q.cnt < thr) begin
                    d.cnt = q.cnt + CW'(1);
                    if (q.cnt == thr - CW'(1)) idle_pulse = 1'b1;
                end
            end else begin
                d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !idle_pulse); // R7

endmodule

// File: rtl/urw_char_check.sv
module urw_char_check #(
    parameter int DMAX = 9
) (
    input  logic [DMAX-1:0] sh,
    input  logic            nine,
    input  logic            par_en,
    input  logic            par_odd,
    output logic [DMAX-1:0] payload,
    output logic            msb,
    output logic            par_bad
);
    logic [DMAX-1:0] aligned;

    always_comb begin
        aligned = nine ? sh : {1'b0, sh[DMAX-1:1]};
        msb     = sh[DMAX-1];
        par_bad = (^aligned) ^ par_odd;
        payload = aligned;
        if (par_en) begin
            if (nine) payload[DMAX-1] = 1'b0;
            else      payload[DMAX-2] = 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
    import uart_rx_wake_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            rxd,
    input  logic            cfg_nine,
    input  logic            cfg_wake_addr,
    input  logic            cfg_idle_after_stop,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            sleep_req,
    output logic [DMAX-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_par_err,
    output logic            rx_frm_err,
    output logic            rx_idle,
    output logic            asleep
);
    typedef struct packed {
        logic [DMAX-1:0] data;
        logic            valid;
        logic            perr;
        logic            ferr;
        logic            idle;
        logic            sleep;
    } top_t;

    top_t q, d;

    logic            fr_done, fr_stop_ok, fr_hunting, fr_in_start;
    logic [DMAX-1:0] fr_sh;
    logic            idle_en, idle_pulse;
    logic [DMAX-1:0] cc_payload;
    logic            cc_msb, cc_par_bad;
    logic            addr_wake, idle_wake, deliver;

    urw_frame_rx #(.OSR(OSR), .DMAX(DMAX)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rxd      (rxd),
        .nine     (cfg_nine),
        .done     (fr_done),
        .stop_ok  (fr_stop_ok),
        .hunting  (fr_hunting),
        .in_start (fr_in_start),
        .shreg    (fr_sh)
    );

    assign idle_en = cfg_idle_after_stop ? fr_hunting : !fr_in_start;

    urw_idle_det #(.OSR(OSR), .DMAX(DMAX)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .rxd        (rxd),
        .en         (idle_en),
        .nine       (cfg_nine),
        .idle_pulse (idle_pulse)
    );

    urw_char_check #(.DMAX(DMAX)) u_check (
        .sh      (fr_sh),
        .nine    (cfg_nine),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .payload (cc_payload),
        .msb     (cc_msb),
        .par_bad (cc_par_bad)
    );

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        d.perr    = 1'b0;
        d.ferr    = 1'b0;
        d.idle    = idle_pulse;
        addr_wake = fr_done && q.sleep && cfg_wake_addr && cc_msb;
        idle_wake = idle_pulse && q.sleep && !cfg_wake_addr;
        deliver   = fr_done && (!q.sleep || addr_wake);
        if (deliver) begin
            d.valid = 1'b1;
            d.data  = cc_payload;
            d.perr  = cfg_par_en && cc_par_bad;
            d.ferr  = !fr_stop_ok;
        end
        if (addr_wake || idle_wake) d.sleep = 1'b0;
        if (sleep_req)              d.sleep = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data    = q.data;
    assign rx_valid   = q.valid;
    assign rx_par_err = q.perr;
    assign rx_frm_err = q.ferr;
    assign rx_idle    = q.idle;
    assign asleep     = q.sleep;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R3

    AST_PERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err |-> rx_valid); // R5

    AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frm_err |-> rx_valid); // R6

    AST_SLEEP_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(asleep) && !$past(sleep_req) && asleep) |-> !rx_valid); // R10

    AST_ADDR_WAKE_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && $past(cfg_wake_addr)) |-> rx_valid); // R11

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && !$past(cfg_wake_addr)) |-> rx_idle); // R12

endmodule

// File: tb/tb_uart_rx_wake.sv
`timescale 1ns/1ps
module tb_uart_rx_wake;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_nine = 1'b0, cfg_wake_addr = 1'b0, cfg_idle_after_stop = 1'b0;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       sleep_req = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_par_err, rx_frm_err, rx_idle, asleep;

    always #2 clk = ~clk;

    uart_rx_wake dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_nine(cfg_nine), .cfg_wake_addr(cfg_wake_addr),
        .cfg_idle_after_stop(cfg_idle_after_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .sleep_req(sleep_req),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_idle(rx_idle), .asleep(asleep)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_hunt = 1, m_prev = 1, m_samp = 0, m_bit = 0, m_ones = 0, m_icnt = 0, m_asleep = 0;
    logic [8:0] m_char = '0;
    int exp_valid = 0, exp_par = 0, exp_frm = 0, exp_idle = 0;
    logic [8:0] exp_data = '0;

    // observation
    int nv = 0, n_idle = 0, last_par = 0, last_frm = 0;
    logic [8:0] last_data = '0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R3 rx_valid", int'(rx_valid), exp_valid);
        chk("R3 rx_data", int'(rx_data), int'(exp_data));
        chk("R5 rx_par_err", int'(rx_par_err), exp_par);
        chk("R6 rx_frm_err", int'(rx_frm_err), exp_frm);
        chk("R7 rx_idle", int'(rx_idle), exp_idle);
        chk("R10 asleep", int'(asleep), m_asleep);
        if (rx_valid) begin
            nv++;
            last_data = rx_data;
            last_par  = int'(rx_par_err);
            last_frm  = int'(rx_frm_err);
        end
        if (rx_idle) n_idle++;
    endtask

    task automatic finish_char(input int v, input int n, input int was_asleep);
        logic [8:0] ch;
        int msb;
        ch = '0;
        for (int i = 0; i < n; i++) ch[i] = m_char[i];
        msb = int'(ch[n-1]);
        if (was_asleep != 0 && cfg_wake_addr && msb != 0) m_asleep = 0;
        if (was_asleep == 0 || (cfg_wake_addr && msb != 0)) begin
            exp_valid = 1;
            exp_frm   = (v == 0) ? 1 : 0;
            exp_par   = (cfg_par_en && (($countones(ch) % 2) != int'(cfg_par_odd))) ? 1 : 0;
            if (cfg_par_en) ch[n-1] = 1'b0;
            exp_data  = ch;
        end
    endtask

    task automatic model_tick(input logic r);
        int n, thr, en, was_hunt, was_start, was_asleep, v;
        n          = cfg_nine ? 9 : 8;
        thr        = 16 * (n + 2);
        was_hunt   = m_hunt;
        was_start  = (m_hunt == 0 && m_bit == 0) ? 1 : 0;
        was_asleep = m_asleep;
        en         = cfg_idle_after_stop ? was_hunt : (was_start == 0 ? 1 : 0);
        if (r && en != 0) begin
            if (m_icnt < thr) begin
                m_icnt++;
                if (m_icnt == thr) exp_idle = 1;
            end
        end else begin
            m_icnt = 0;
        end
        if (was_hunt != 0) begin
            if (m_prev != 0 && !r) begin
                m_hunt = 0; m_samp = 1; m_bit = 0; m_ones = 0;
            end
        end else begin
            m_samp++;
            if (m_samp >= 7 && m_samp <= 9 && r) m_ones++;
            if (m_samp == 9) begin
                v = (m_ones >= 2) ? 1 : 0;
                m_ones = 0;
                if (m_bit == 0) begin
                    if (v != 0) m_hunt = 1;
                end else if (m_bit <= n) begin
                    m_char[m_bit-1] = v[0];
                end else begin
                    finish_char(v, n, was_asleep);
                    m_hunt = 1;
                end
            end
            if (m_hunt == 0 && m_samp == 16) begin
                m_samp = 0;
                m_bit++;
            end
        end
        if (exp_idle != 0 && was_asleep != 0 && !cfg_wake_addr) m_asleep = 0;
        m_prev = int'(r);
    endtask

    task automatic cyc(input logic t, input logic r, input logic s);
        @(negedge clk);
        compare();
        os_tick = t; rxd = r; sleep_req = s;
        exp_valid = 0; exp_par = 0; exp_frm = 0; exp_idle = 0;
        if (t) model_tick(r);
        if (s) m_asleep = 1;
        @(posedge clk);
        #1;
    endtask

    task automatic tk(input logic r);
        cyc(1'b1, r, 1'b0);
        cyc(1'b0, r, 1'b0);
    endtask

    task automatic line(input logic r, input int n);
        for (int i = 0; i < n; i++) tk(r);
    endtask

    task automatic send(input logic [8:0] ch, input int nb, input logic stopv, input bit glitch);
        for (int t = 1; t <= 16; t++) tk((glitch && t == 8) ? 1'b1 : 1'b0);
        for (int i = 0; i < nb; i++) line(ch[i], 16);
        line(stopv, 16);
    endtask

    task automatic sleep_pulse();
        cyc(1'b0, rxd, 1'b1);
        cyc(1'b0, rxd, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int i0, v0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 rx_par_err", int'(rx_par_err), 0);
        chk("R1 rx_frm_err", int'(rx_frm_err), 0);
        chk("R1 rx_idle", int'(rx_idle), 0);
        chk("R1 asleep", int'(asleep), 0);
        @(posedge clk); #1;

        // R7 idle after a long high line, only once
        line(1'b1, 200);
        chk("R7 one idle pulse", n_idle, 1);
        line(1'b1, 100);
        chk("R7 no repeat idle", n_idle, 1);

        // R3 8-bit characters
        send(9'h0A5, 8, 1'b1, 0); line(1'b1, 4);
        chk("R3 byte A5", int'(last_data), 'hA5);
        chk("R3 count", nv, 1);

        // R2 glitched start sample 8 still accepted
        send(9'h03C, 8, 1'b1, 1); line(1'b1, 4);
        chk("R2 glitch start data", int'(last_data), 'h3C);
        chk("R2 glitch start count", nv, 2);

        // R2 false start
        line(1'b0, 6); line(1'b1, 40);
        chk("R2 false start no char", nv, 2);

        // R4 9-bit
        cfg_nine = 1'b1;
        send(9'h1A5, 9, 1'b1, 0); line(1'b1, 4);
        chk("R4 nine-bit data", int'(last_data), 'h1A5);

        // R5 parity
        cfg_nine = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(9'h041, 8, 1'b1, 0); line(1'b1, 4);
        chk("R5 even ok data", int'(last_data), 'h41);
        chk("R5 even ok flag", last_par, 0);
        send(9'h0C1, 8, 1'b1, 0); line(1'b1, 4);
        chk("R5 even bad data", int'(last_data), 'h41);
        chk("R5 even bad flag", last_par, 1);
        cfg_par_odd = 1'b1;
        send(9'h0C1, 8, 1'b1, 0); line(1'b1, 4);
        chk("R5 odd ok flag", last_par, 0);
        cfg_nine = 1'b1;
        send(9'h101, 9, 1'b1, 0); line(1'b1, 4);
        chk("R5 nine-bit parity data", int'(last_data), 'h001);
        chk("R5 nine-bit odd bad", last_par, 1);
        cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R6 framing
        send(9'h055, 8, 1'b0, 0); line(1'b1, 40);
        chk("R6 framing flag", last_frm, 1);
        chk("R6 data", int'(last_data), 'h55);

        // R8 false idle with counting after start bit
        line(1'b1, 200);
        i0 = n_idle;
        send(9'h0FF, 8, 1'b1, 0); line(1'b1, 32); send(9'h000, 8, 1'b1, 0);
        chk("R8 false idle reported", n_idle - i0, 1);

        // R9 counting after stop bit
        cfg_idle_after_stop = 1'b1;
        line(1'b1, 200);
        i0 = n_idle;
        send(9'h0FF, 8, 1'b1, 0); line(1'b1, 32); send(9'h000, 8, 1'b1, 0);
        chk("R9 no false idle", n_idle - i0, 0);
        line(1'b1, 200);
        chk("R9 real idle", n_idle - i0, 1);
        cfg_idle_after_stop = 1'b0;

        // R10 / R11 address-mark wakeup
        cfg_nine = 1'b1; cfg_wake_addr = 1'b1;
        sleep_pulse();
        chk("R10 asleep set", int'(asleep), 1);
        v0 = nv;
        send(9'h055, 9, 1'b1, 0); line(1'b1, 4);
        chk("R10 suppressed", nv, v0);
        chk("R11 stays asleep", int'(asleep), 1);
        send(9'h1AA, 9, 1'b1, 0); line(1'b1, 4);
        chk("R11 wake char delivered", nv, v0 + 1);
        chk("R11 wake char data", int'(last_data), 'h1AA);
        chk("R11 awake", int'(asleep), 0);

        // R12 idle wakeup
        cfg_nine = 1'b0; cfg_wake_addr = 1'b0;
        line(1'b1, 20);
        sleep_pulse();
        v0 = nv;
        send(9'h012, 8, 1'b0, 0); line(1'b1, 32);
        chk("R10 error suppressed", nv, v0);
        chk("R12 not yet awake", int'(asleep), 1);
        line(1'b1, 200);
        chk("R12 woke on idle", int'(asleep), 0);
        send(9'h034, 8, 1'b1, 0); line(1'b1, 4);
        chk("R12 delivery resumes", nv, v0 + 1);
        chk("R12 data", int'(last_data), 'h34);

        @(negedge clk);
        compare();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule